// File: doc/BRIEF.md
# Single-Tone I/Q Correlation Demodulator

This block measures one known tone in a stream of signed 12-bit converter samples. A start pulse opens a window of exactly 1600 accepted samples. Each sample is multiplied by a cosine and a sine reference from an internal phase accumulator, and the two products are summed into full-precision in-phase and quadrature totals. When the window closes, a one-cycle done strobe marks the I and Q sums, together with their squared magnitude I²+Q², as valid. Those values stay on the outputs until the next start. Arctangent and square root are left to the consumer.

The reference advances by a programmed phase increment per accepted sample. Software picks the increment so that the 1600-sample window spans a whole number of reference cycles. For tones above half the sample rate, it programs the aliased frequency |fIn − n·Fs| instead. The phase wraps modulo 2^16, so any such alias can be expressed directly.

A separate rate divider turns the fast clock into a one-cycle sample-enable every `div_ratio` cycles. For slow tones this lowers the sample rate to 1600 times the input frequency, which keeps each window an integer number of periods.

Top module: `tone_iq_demod`

## Requirements
- R1: While reset is held and after its release, `done`, `acc_i`, `acc_q` and `pwr` are zero, and `smp_tick` is low during reset.
- R2: `start` clears both sums and opens a window of exactly 1600 accepted samples. `done` rises on the first clock edge after the edge that accepts the 1600th sample, and never earlier.
- R3: The reference phase is a 16-bit accumulator that is zero for the first sample of a window and grows by `phase_inc` (mod 2^16) after each accepted sample. At phases 0x0000, 0x4000, 0x8000 and 0xC000 the cosine is +2047, 0, −2047, 0 and the sine is 0, +2047, 0, −2047. `acc_i` = Σ sample·cos and `acc_q` = Σ sample·sin.
- R4: The sums are 35-bit signed and hold 1600 full-scale products without overflow; for example, 1600 samples of −2048 at increment 0 give I = −6707609600.
- R5: While `done` is high, `pwr` equals acc_i² + acc_q² as a 70-bit unsigned value.
- R6: `done` is high for exactly one cycle. `acc_i`, `acc_q` and `pwr` keep their values after it until the next `start`.
- R7: Cycles with `smp_valid` low, and valid samples arriving while no window is open, change neither sum and cause no `done`.
- R8: `phase_inc` is captured at `start`; changing it inside a window has no effect on that window.
- R9: A `start` inside an open window discards the partial sums and begins a fresh 1600-sample window.
- R10: `smp_tick` is a one-cycle pulse every `div_ratio` clock cycles; a ratio of 0 or 1 gives a pulse on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a new window and captures `phase_inc` |
| phase_inc | input | 16 | Reference phase step per accepted sample |
| smp_valid | input | 1 | `smp_data` carries a sample this cycle |
| smp_data | input | 12 | Signed converter sample |
| div_ratio | input | 16 | Clock cycles per sample-enable pulse |
| smp_tick | output | 1 | Sample-enable pulse from the rate divider |
| done | output | 1 | One-cycle strobe: window results valid |
| acc_i | output | 35 | Signed in-phase sum |
| acc_q | output | 35 | Signed quadrature sum |
| pwr | output | 70 | acc_i² + acc_q² |

## Verification
The bench feeds whole windows at the four quadrant increments, including 0xC000, where a wrong phase wrap or sine/cosine sign swap flips the quadrature total. A full-scale negative window catches accumulators that are too narrow or lose the sign, because they would report a wrapped or positive sum. Interleaved invalid cycles, idle samples after a window, an increment change mid-window and a restart mid-window each expose designs that count the wrong samples, keep a stale partial sum or use the live increment. Their totals would differ from the bench's own sum, or `done` would fire early or twice. The divider is timed at several ratios, so an off-by-one count shows up as a wrong pulse interval.

// File: rtl/iq_demod_pkg.sv
package iq_demod_pkg;

   typedef enum logic {
      LANE_I = 1'b0,
      LANE_Q = 1'b1
   } lane_e;

   // Rational sine approximation over a half turn; exact at 0 and 90 degrees.
   // idx runs 0..qlen for the first quarter.
   function automatic longint quarter_sine(input longint idx, input longint qlen,
                                           input longint amp);
      longint h;
      longint p;
      longint num;
      longint den;
      h   = 2 * qlen;
      p   = idx * (h - idx);
      num = 16 * p * amp;
      den = 5 * h * h - 4 * p;
      return (num + den / 2) / den;
   endfunction

endpackage

// File: rtl/iq_rate_div.sv
module iq_rate_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ratio,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;
   logic             short_ratio;
   logic [DIV_W-1:0] last_cnt;

   assign short_ratio = (ratio <= DIV_W'(1));
   assign last_cnt    = ratio - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (short_ratio) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else if (cnt_q >= last_cnt) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
         tick  <= 1'b0;
      end
   end

endmodule

// File: rtl/iq_ref_nco.sv
module iq_ref_nco
   import iq_demod_pkg::*;
#(
   parameter int PHASE_W = 16,
   parameter int LUT_AW  = 6,
   parameter int REF_W   = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    step,
   input  logic [PHASE_W-1:0]      inc_in,
   output logic signed [REF_W-1:0] cos_o,
   output logic signed [REF_W-1:0] sin_o
);

   localparam int     QLEN = 1 << LUT_AW;
   localparam longint AMP  = (longint'(1) << (REF_W - 1)) - 1;

   logic signed [REF_W-1:0] lut [0:QLEN];

   for (genvar i = 0; i <= QLEN; i++) begin : g_lut
      assign lut[i] = REF_W'(quarter_sine(i, QLEN, AMP));
   end

   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] inc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         inc_q   <= '0;
      end else if (load) begin
         phase_q <= '0;
         inc_q   <= inc_in;
      end else if (step) begin
         phase_q <= phase_q + inc_q;
      end
   end

   logic [1:0]        quad;
   logic [LUT_AW-1:0] idx;
   logic [LUT_AW:0]   fidx;
   logic [LUT_AW:0]   ridx;
   logic              unused_lsb;
   logic signed [REF_W-1:0] fwd;
   logic signed [REF_W-1:0] rev;

   assign quad       = phase_q[PHASE_W-1 -: 2];
   assign idx        = phase_q[PHASE_W-3 -: LUT_AW];
   assign unused_lsb = ^phase_q[PHASE_W-LUT_AW-3:0];
   assign fidx       = {1'b0, idx};
   assign ridx       = (LUT_AW+1)'(QLEN) - fidx;
   assign fwd        = lut[fidx];
   assign rev        = lut[ridx];

   always_comb begin
      unique case (quad)
         2'd0: begin sin_o = fwd;  cos_o = rev;  end
         2'd1: begin sin_o = rev;  cos_o = -fwd; end
         2'd2: begin sin_o = -fwd; cos_o = -rev; end
         default: begin sin_o = -rev; cos_o = fwd; end
      endcase
   end

endmodule

// File: rtl/iq_mac.sv
module iq_mac #(
   parameter int X_W   = 12,
   parameter int R_W   = 12,
   parameter int ACC_W = 35
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    en,
   input  logic signed [X_W-1:0]   x_in,
   input  logic signed [R_W-1:0]   ref_in,
   output logic signed [ACC_W-1:0] acc_o
);

   localparam int PW = X_W + R_W;

   logic signed [PW-1:0] prod;

   assign prod = PW'(x_in) * PW'(ref_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o <= '0;
      end else if (clr) begin
         acc_o <= '0;
      end else if (en) begin
         acc_o <= acc_o + ACC_W'(prod);
      end
   end

endmodule

// File: rtl/iq_win_ctrl.sv
module iq_win_ctrl #(
   parameter int WIN_LEN = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic smp_valid,
   output logic busy,
   output logic acc_en,
   output logic fin,
   output logic done
);

   localparam int CNT_W = $clog2(WIN_LEN + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             last_hit;

   assign acc_en   = busy && smp_valid && !start;
   assign last_hit = acc_en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
         fin   <= 1'b0;
         done  <= 1'b0;
      end else begin
         fin  <= last_hit;
         done <= fin;
         if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
         end else if (last_hit) begin
            busy  <= 1'b0;
            cnt_q <= '0;
         end else if (acc_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/tone_iq_demod.sv
module tone_iq_demod
   import iq_demod_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int REF_W    = 12,
   parameter int PHASE_W  = 16,
   parameter int LUT_AW   = 6,
   parameter int WIN_LEN  = 1600,
   parameter int DIV_W    = 16,
   parameter bit PWR_EN   = 1'b1,
   parameter int ACC_W    = SAMPLE_W + REF_W + $clog2(WIN_LEN),
   parameter int PWR_W    = 2 * ACC_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [PHASE_W-1:0]      phase_inc,
   input  logic                    smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   input  logic [DIV_W-1:0]        div_ratio,
   output logic                    smp_tick,
   output logic                    done,
   output logic signed [ACC_W-1:0] acc_i,
   output logic signed [ACC_W-1:0] acc_q,
   output logic [PWR_W-1:0]        pwr
);

   localparam int MIN_ACC_W = SAMPLE_W + REF_W + $clog2(WIN_LEN);

   if (WIN_LEN < 2) begin : g_chk_win
      $error("WIN_LEN must be at least 2");
   end
   if (PHASE_W <= LUT_AW + 2) begin : g_chk_phase
      $error("PHASE_W must exceed LUT_AW + 2");
   end
   if (ACC_W < MIN_ACC_W) begin : g_chk_acc
      $error("ACC_W too narrow for the window");
   end
   if (PWR_W < 2 * ACC_W) begin : g_chk_pwr
      $error("PWR_W too narrow for the squared sums");
   end

   logic win_busy;
   logic acc_en;
   logic win_fin;

   iq_win_ctrl #(.WIN_LEN(WIN_LEN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .smp_valid(smp_valid),
      .busy     (win_busy),
      .acc_en   (acc_en),
      .fin      (win_fin),
      .done     (done)
   );

   iq_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .ratio(div_ratio),
      .tick (smp_tick)
   );

   logic signed [REF_W-1:0] ref_w [2];

   iq_ref_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .REF_W(REF_W)) u_nco (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .step  (acc_en),
      .inc_in(phase_inc),
      .cos_o (ref_w[int'(LANE_I)]),
      .sin_o (ref_w[int'(LANE_Q)])
   );

   logic signed [ACC_W-1:0] acc_w [2];

   for (genvar g = 0; g < 2; g++) begin : g_lane
      iq_mac #(.X_W(SAMPLE_W), .R_W(REF_W), .ACC_W(ACC_W)) u_mac (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (start),
         .en    (acc_en),
         .x_in  (smp_data),
         .ref_in(ref_w[g]),
         .acc_o (acc_w[g])
      );
   end

   assign acc_i = acc_w[int'(LANE_I)];
   assign acc_q = acc_w[int'(LANE_Q)];

   if (PWR_EN) begin : g_pwr
      logic signed [PWR_W-1:0] sq_i;
      logic signed [PWR_W-1:0] sq_q;
      logic [PWR_W-1:0]        pwr_q;

      assign sq_i = PWR_W'(acc_i) * PWR_W'(acc_i);
      assign sq_q = PWR_W'(acc_q) * PWR_W'(acc_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pwr_q <= '0;
         end else if (win_fin) begin
            pwr_q <= sq_i + sq_q;
         end
      end
      assign pwr = pwr_q;
   end else begin : g_no_pwr
      assign pwr = '0;
   end

endmodule

// File: rtl/tone_iq_demod_chk.sv
module tone_iq_demod_chk #(
   parameter int ACC_W = 35,
   parameter int DIV_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    win_busy,
   input logic                    done,
   input logic signed [ACC_W-1:0] acc_i,
   input logic signed [ACC_W-1:0] acc_q,
   input logic                    smp_tick,
   input logic [DIV_W-1:0]        div_ratio
);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done wider than one cycle"); // R6

   AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (acc_i == '0 && acc_q == '0)) else $error("start did not clear"); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_busy && !start) |=> ($stable(acc_i) && $stable(acc_q)))
      else $error("sums moved outside a window"); // R7

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_tick && div_ratio > DIV_W'(1)) |=> !smp_tick)
      else $error("tick too wide"); // R10

endmodule

bind tone_iq_demod tone_iq_demod_chk #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .win_busy (win_busy),
   .done     (done),
   .acc_i    (acc_i),
   .acc_q    (acc_q),
   .smp_tick (smp_tick),
   .div_ratio(div_ratio)
);

// File: tb/test_tone_iq_demod.sv
module test_tone_iq_demod;

   localparam int ACC_W = 35;
   localparam int PWR_W = 70;
   localparam int WIN   = 1600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [15:0] phase_inc = '0;
   logic smp_valid = 1'b0;
   logic signed [11:0] smp_data = '0;
   logic [15:0] div_ratio = 16'd4;
   logic smp_tick;
   logic done;
   logic signed [ACC_W-1:0] acc_i;
   logic signed [ACC_W-1:0] acc_q;
   logic [PWR_W-1:0] pwr;

   always #2 clk = ~clk;

   tone_iq_demod i_tone_iq_demod (
      .clk(clk), .rst_n(rst_n), .start(start), .phase_inc(phase_inc),
      .smp_valid(smp_valid), .smp_data(smp_data), .div_ratio(div_ratio),
      .smp_tick(smp_tick), .done(done), .acc_i(acc_i), .acc_q(acc_q), .pwr(pwr)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   longint exp_i;
   longint exp_q;
   bit early_done;

   task automatic check(input bit ok, input string req, input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s", req, what);
      end
   endtask

   function automatic int samp(input int pat, input int k);
      case (pat)
         0: return 100;
         1: return ((k * 37) % 4095) - 2047;
         2: return -2048;
         default: return 1500;
      endcase
   endfunction

   function automatic int ref_val(input bit is_sin, input int k, input int inc);
      int q;
      q = ((k * inc) >> 14) & 3;
      if (!is_sin) return (q == 0) ? 2047 : (q == 2) ? -2047 : 0;
      return (q == 1) ? 2047 : (q == 3) ? -2047 : 0;
   endfunction

   task automatic pulse_start(input logic [15:0] inc);
      @(negedge clk);
      start = 1'b1; phase_inc = inc; smp_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Starts a window and feeds it; expected sums go to exp_i/exp_q.
   task automatic window(input logic [15:0] inc, input int pat, input bit gaps,
                         input bit change_inc);
      exp_i = 0; exp_q = 0; early_done = 1'b0;
      pulse_start(inc);
      for (int k = 0; k < WIN; k++) begin
         if (gaps && (k % 3 == 0)) begin
            smp_valid = 1'b0; smp_data = 12'sd777;
            @(negedge clk);
         end
         if (done) early_done = 1'b1;
         if (change_inc && k == 10) phase_inc = 16'h1234;
         smp_valid = 1'b1;
         smp_data  = 12'(samp(pat, k));
         exp_i += longint'(samp(pat, k)) * ref_val(1'b0, k, int'(inc));
         exp_q += longint'(samp(pat, k)) * ref_val(1'b1, k, int'(inc));
         @(negedge clk);
      end
      smp_valid = 1'b0;
   endtask

   task automatic expect_result(input string req);
      int waited;
      logic signed [PWR_W-1:0] ei;
      logic signed [PWR_W-1:0] eq;
      logic [PWR_W-1:0] ep;
      logic signed [ACC_W-1:0] held_i;
      waited = 0;
      while (!done && waited < 6) begin
         @(negedge clk);
         waited++;
      end
      check(!early_done, "R2", $sformatf("done before window end act=1 exp=0"));
      check(waited == 1, "R2", $sformatf("done latency act=%0d exp=1", waited));
      check(acc_i == exp_i, req, $sformatf("I act=%0d exp=%0d", acc_i, exp_i));
      check(acc_q == exp_q, req, $sformatf("Q act=%0d exp=%0d", acc_q, exp_q));
      ei = exp_i; eq = exp_q;
      ep = PWR_W'(ei * ei + eq * eq);
      check(pwr == ep, "R5", $sformatf("pwr act=%0d exp=%0d", pwr, ep));
      held_i = acc_i;
      @(negedge clk);
      check(!done, "R6", $sformatf("done width act=%0b exp=0", done));
      check(acc_i == held_i && pwr == ep, "R6",
            $sformatf("hold I act=%0d exp=%0d", acc_i, held_i));
   endtask

   task automatic t_reset();
      check(done == 1'b0 && smp_tick == 1'b0, "R1",
            $sformatf("reset done/tick act=%0b%0b exp=00", done, smp_tick));
      check(acc_i == 0 && acc_q == 0 && pwr == 0, "R1",
            $sformatf("reset sums act=%0d/%0d/%0d exp=0", acc_i, acc_q, pwr));
   endtask

   task automatic t_quadrants();
      window(16'h0000, 0, 1'b0, 1'b0); expect_result("R3");
      window(16'h4000, 1, 1'b0, 1'b0); expect_result("R3");
      window(16'h8000, 1, 1'b0, 1'b0); expect_result("R3");
      window(16'hC000, 1, 1'b0, 1'b0); expect_result("R3");
   endtask

   task automatic t_fullscale();
      window(16'h0000, 2, 1'b0, 1'b0);
      check(exp_i == -64'sd6707609600, "R4", $sformatf("bench exp act=%0d exp=-6707609600", exp_i));
      expect_result("R4");
   endtask

   task automatic t_gaps();
      window(16'h4000, 1, 1'b1, 1'b0); expect_result("R7");
   endtask

   task automatic t_idle();
      logic signed [ACC_W-1:0] hi;
      logic signed [ACC_W-1:0] hq;
      bit seen;
      hi = acc_i; hq = acc_q; seen = 1'b0;
      for (int k = 0; k < 40; k++) begin
         smp_valid = 1'b1; smp_data = 12'sd1000;
         @(negedge clk);
         if (done) seen = 1'b1;
      end
      smp_valid = 1'b0;
      @(negedge clk);
      check(acc_i == hi && acc_q == hq, "R7",
            $sformatf("idle sums act=%0d/%0d exp=%0d/%0d", acc_i, acc_q, hi, hq));
      check(!seen, "R7", $sformatf("idle done act=1 exp=0"));
   endtask

   task automatic t_inc_change();
      window(16'h4000, 1, 1'b0, 1'b1); expect_result("R8");
   endtask

   task automatic t_restart();
      pulse_start(16'h8000);
      for (int k = 0; k < 500; k++) begin
         smp_valid = 1'b1; smp_data = 12'(samp(3, k));
         @(negedge clk);
      end
      smp_valid = 1'b0;
      window(16'h0000, 1, 1'b0, 1'b0); expect_result("R9");
   endtask

   task automatic t_divider(input logic [15:0] r);
      int gap;
      int tries;
      @(negedge clk);
      div_ratio = r;
      repeat (2 * int'(r) + 4) @(negedge clk);
      if (r <= 1) begin
         for (int k = 0; k < 5; k++) begin
            check(smp_tick, "R10", $sformatf("ratio %0d tick act=%0b exp=1", r, smp_tick));
            @(negedge clk);
         end
      end else begin
         tries = 0;
         while (!smp_tick && tries < int'(r) + 2) begin
            @(negedge clk); tries++;
         end
         for (int n = 0; n < 3; n++) begin
            gap = 0;
            do begin
               @(negedge clk); gap++;
            end while (!smp_tick && gap < 64);
            check(gap == int'(r), "R10", $sformatf("tick period act=%0d exp=%0d", gap, r));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && acc_i == 0 && pwr == 0, "R1",
            $sformatf("post-reset done/I act=%0b/%0d exp=0/0", done, acc_i));
      t_quadrants();
      t_fullscale();
      t_gaps();
      t_idle();
      t_inc_change();
      t_restart();
      t_divider(16'd5);
      t_divider(16'd3);
      t_divider(16'd1);
      t_divider(16'd0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule